// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is the data path of a small 8-bit processor core that has two accumulators and a 16-bit register formed by joining them. Each cycle the core presents an operation code and up to two operands. The unit returns the result at once, with no register in the path, together with a marker that says whether the result should be written back. It also computes fresh values for four condition flags: negative, zero, two's-complement overflow and carry/borrow.

The flags live in a small registered condition-code nibble at the output. On a clock edge the nibble takes the new flag values only while the flag-write enable is high. Each operation changes only the flags it defines and leaves the others as they were. Compare, test and bit-test operations set the flags but mark their result as not to be written. A mask operation ANDs the nibble with an operand, so the core can clear any group of flags in one step.

Operands are 16 bits wide. Every operation except the wide compare uses the low byte and returns a zero-extended byte. Multiply returns the full 16-bit product. The wide compare uses both full operands.

Top module: `nzvc_alu`

## Requirements
- R1: Operation code 0x0 (add) returns opa[7:0]+opb[7:0] with write marked. It sets N to result bit 7, Z when the result byte is zero, V when both operands have the same sign and the result sign differs, and C to the carry out of bit 7.
- R2: Operation code 0x1 (subtract) returns opa[7:0]-opb[7:0] with write marked. It sets C on an unsigned borrow, and V when the operand signs differ and the result sign differs from the minuend. N and Z work as in R1.
- R3: Operation code 0x2 (byte compare) and 0x3 (16-bit compare on the full operands) set N, Z, V and C as a subtraction of that width does, and leave write unmarked. For the wide compare, N is bit 15 and Z tests all 16 bits.
- R4: Operation code 0x4 (test) sets N and Z from opa[7:0], clears V and C, and leaves write unmarked.
- R5: Operation code 0x5 (AND) and 0x6 (exclusive OR) return the bitwise result with write marked. Operation code 0x7 (bit test) forms the AND with write unmarked. All three set N and Z from the result, clear V and keep C.
- R6: Operation code 0x8 (clear) returns 0 and sets the flags to N=0, Z=1, V=0, C=0. Operation code 0x9 (complement) returns the one's complement, sets N and Z, clears V and sets C.
- R7: Operation code 0xA (negate) returns 0-opa[7:0] with write marked. Flags are set as for subtracting the operand from zero, so C is set for every nonzero operand and V only for 0x80.
- R8: Operation code 0xB (logical shift left) shifts a zero into bit 0, and C takes the old bit 7. Operation code 0xC (arithmetic shift right) keeps bit 7, and C takes the old bit 0. Both set N and Z from the result and set V to N XOR C.
- R9: Operation code 0xD (multiply) returns the 16-bit unsigned product of opa[7:0] and opb[7:0] with write marked. It sets C to product bit 7 and keeps N, Z and V.
- R10: Operation code 0xE (flag mask) ANDs the flag nibble with opb[3:0] and leaves write unmarked. Operation code 0xF does nothing: write unmarked and flags kept.
- R11: While flag_we_i is low, the flag nibble holds its value whatever the operation.
- R12: The flag nibble is N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. It reads 0 in reset, clears at once when rst_ni falls, and updates on the rising edge after the operation is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | First operand (register side) |
| opb_i | input | 16 | Second operand or flag mask |
| flag_we_i | input | 1 | Flag-write enable |
| res_o | output | 16 | Result, combinational |
| res_wr_o | output | 1 | Result should be written back |
| ccr_o | output | 4 | Registered flags {N,Z,V,C} |

## Verification
The bench targets the signed and unsigned boundaries. It covers 0x7F+1 and 0x80-1, where a wrong overflow term would miss V or set it for the wrong sign. It covers negating 0x80 and 0x00, where a bad borrow would invert C. It covers a wide compare whose result sign differs from its low byte, so a byte-wide flag decode would report the wrong N and Z. It checks that carry survives logic operations and that multiply changes only C, which catches any update that writes all four flags at once. It also checks shifts whose V comes out from N XOR C, a mask whose low nibble is zero, and operations with the flag enable low, which would show a register that ignores its enable.

// File: rtl/nzvc_alu_pkg.sv
package nzvc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_CMPB  = 4'h2,
    OP_CMPW  = 4'h3,
    OP_TST   = 4'h4,
    OP_AND   = 4'h5,
    OP_EOR   = 4'h6,
    OP_BIT   = 4'h7,
    OP_CLR   = 4'h8,
    OP_COM   = 4'h9,
    OP_NEG   = 4'hA,
    OP_LSL   = 4'hB,
    OP_ASR   = 4'hC,
    OP_MUL   = 4'hD,
    OP_MASK  = 4'hE,
    OP_NOP   = 4'hF
  } alu_op_e;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_V  = 1;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_N  = 3;

  typedef struct packed {
    logic              wr;
    logic              wide;
    logic [FLAG_W-1:0] upd;
  } op_ctl_t;

  function automatic op_ctl_t decode_op(alu_op_e op);
    op_ctl_t c;
    c.wr   = 1'b0;
    c.wide = 1'b0;
    c.upd  = 4'b0000;
    unique case (op)
      OP_ADD, OP_SUB, OP_COM, OP_NEG,
      OP_LSL, OP_ASR, OP_CLR:  begin c.wr = 1'b1; c.upd = 4'b1111; end
      OP_AND, OP_EOR:          begin c.wr = 1'b1; c.upd = 4'b1110; end
      OP_BIT:                  c.upd = 4'b1110;
      OP_CMPB, OP_TST, OP_MASK: c.upd = 4'b1111;
      OP_CMPW:                 begin c.wide = 1'b1; c.upd = 4'b1111; end
      OP_MUL:                  begin c.wr = 1'b1; c.wide = 1'b1; c.upd = 4'b0001; end
      default:                 c.upd = 4'b0000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nzvc_rstsync.sv
module nzvc_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sn_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sn_o = sync_q[STAGES-1];
endmodule

// File: rtl/nzvc_addsub.sv
module nzvc_addsub #(
  parameter int unsigned W = 8
) (
  input  logic         sub_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] y_eff;
  logic [W:0]   full;

  always_comb begin
    y_eff = sub_i ? ~y_i : y_i;
    full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, sub_i};
    sum_o = full[W-1:0];
    // carry for add, borrow (inverted carry) for subtract
    c_o   = sub_i ? ~full[W] : full[W];
    v_o   = (x_i[MSB] == y_eff[MSB]) && (sum_o[MSB] != x_i[MSB]);
  end
endmodule

// File: rtl/nzvc_shift.sv
module nzvc_shift #(
  parameter int unsigned W = 8
) (
  input  logic         right_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         out_o
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    if (right_i) begin
      q_o   = {d_i[MSB], d_i[MSB:1]};
      out_o = d_i[0];
    end else begin
      q_o   = {d_i[MSB-1:0], 1'b0};
      out_o = d_i[MSB];
    end
  end
endmodule

// File: rtl/nzvc_ccreg.sv
module nzvc_ccreg
  import nzvc_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_sn_i,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] upd_i,
  input  logic [FLAG_W-1:0] nx_i,
  output logic [FLAG_W-1:0] ccr_o
);
  logic [FLAG_W-1:0] ccr_q;
  logic [FLAG_W-1:0] ccr_d;

  always_comb begin
    ccr_d = ccr_q;
    if (we_i) ccr_d = (upd_i & nx_i) | (~upd_i & ccr_q);
  end

  always_ff @(posedge clk_i or negedge rst_sn_i) begin
    if (!rst_sn_i) ccr_q <= '0;
    else           ccr_q <= ccr_d;
  end

  assign ccr_o = ccr_q;

  // R11: disabled writes leave the nibble alone
  assert_hold_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_sn_i)
    !we_i |=> $stable(ccr_q));

  // R11: flags outside the update set keep their value
  assert_keep_unselected_R11: assert property (@(posedge clk_i) disable iff (!rst_sn_i)
    (we_i && upd_i == 4'b0001) |=> (ccr_q[3:1] == $past(ccr_q[3:1])));
endmodule

// File: rtl/nzvc_alu.sv
module nzvc_alu
  import nzvc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      op_i,
  input  logic [2*DW-1:0] opa_i,
  input  logic [2*DW-1:0] opb_i,
  input  logic            flag_we_i,
  output logic [2*DW-1:0] res_o,
  output logic            res_wr_o,
  output logic [3:0]      ccr_o
);
  localparam int unsigned WW  = 2 * DW;
  localparam int unsigned MSB = DW - 1;

  alu_op_e     op;
  op_ctl_t     ctl;
  logic        rst_sn;

  logic [DW-1:0] a8;
  logic [DW-1:0] b8;
  logic [DW-1:0] as_x;
  logic [DW-1:0] as_y;
  logic [DW-1:0] as_sum;
  logic          as_c;
  logic          as_v;
  logic          as_sub;

  logic [WW-1:0] cw_sum;
  logic          cw_c;
  logic          cw_v;

  logic [DW-1:0] sh_q;
  logic          sh_out;
  logic [WW-1:0] prod;

  logic [DW-1:0]     byte_res;
  logic              v_nx;
  logic              c_nx;
  logic [FLAG_W-1:0] flags_nx;
  logic [FLAG_W-1:0] ccr_q;
  logic              n_bit;
  logic              z_bit;

  assign op  = alu_op_e'(op_i);
  assign ctl = decode_op(op);
  assign a8  = opa_i[DW-1:0];
  assign b8  = opb_i[DW-1:0];

  nzvc_rstsync #(.STAGES(2)) u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_sn_o (rst_sn)
  );

  // byte adder shared by add, subtract, compare, test and negate
  always_comb begin
    as_x   = (op == OP_NEG) ? '0 : a8;
    as_y   = (op == OP_NEG) ? a8 : ((op == OP_TST) ? '0 : b8);
    as_sub = (op != OP_ADD);
  end

  nzvc_addsub #(.W(DW)) u_as_byte (
    .sub_i (as_sub),
    .x_i   (as_x),
    .y_i   (as_y),
    .sum_o (as_sum),
    .c_o   (as_c),
    .v_o   (as_v)
  );

  nzvc_addsub #(.W(WW)) u_as_wide (
    .sub_i (1'b1),
    .x_i   (opa_i),
    .y_i   (opb_i),
    .sum_o (cw_sum),
    .c_o   (cw_c),
    .v_o   (cw_v)
  );

  nzvc_shift #(.W(DW)) u_shift (
    .right_i (op == OP_ASR),
    .d_i     (a8),
    .q_o     (sh_q),
    .out_o   (sh_out)
  );

  assign prod = WW'(a8) * WW'(b8);

  always_comb begin
    byte_res = '0;
    v_nx     = 1'b0;
    c_nx     = ccr_q[FLG_C];
    unique case (op)
      OP_ADD, OP_SUB, OP_CMPB, OP_NEG: begin
        byte_res = as_sum;
        v_nx     = as_v;
        c_nx     = as_c;
      end
      OP_TST: begin
        byte_res = as_sum;
        c_nx     = 1'b0;
      end
      OP_AND, OP_BIT: byte_res = a8 & b8;
      OP_EOR:         byte_res = a8 ^ b8;
      OP_CLR:         c_nx     = 1'b0;
      OP_COM: begin
        byte_res = ~a8;
        c_nx     = 1'b1;
      end
      OP_LSL, OP_ASR: begin
        byte_res = sh_q;
        c_nx     = sh_out;
        v_nx     = sh_q[MSB] ^ sh_out;
      end
      OP_CMPW: begin
        v_nx = cw_v;
        c_nx = cw_c;
      end
      OP_MUL:  c_nx = prod[MSB];
      default: byte_res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_CMPW) res_o = cw_sum;
    else if (op == OP_MUL) res_o = prod;
    else res_o = {{DW{1'b0}}, byte_res};
    n_bit = ctl.wide ? res_o[WW-1] : res_o[MSB];
    z_bit = ctl.wide ? (res_o == '0) : (res_o[DW-1:0] == '0);
    if (op == OP_MASK) begin
      flags_nx = ccr_q & opb_i[FLAG_W-1:0];
    end else begin
      flags_nx        = '0;
      flags_nx[FLG_N] = n_bit;
      flags_nx[FLG_Z] = z_bit;
      flags_nx[FLG_V] = v_nx;
      flags_nx[FLG_C] = c_nx;
    end
  end

  assign res_wr_o = ctl.wr;

  nzvc_ccreg u_ccr (
    .clk_i    (clk_i),
    .rst_sn_i (rst_sn),
    .we_i     (flag_we_i),
    .upd_i    (ctl.upd),
    .nx_i     (flags_nx),
    .ccr_o    (ccr_q)
  );

  assign ccr_o = ccr_q;

  // R6: clear always lands on Z alone
  assert_clear_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (flag_we_i && op == OP_CLR) |=> (ccr_q == 4'b0100));

  // R8: shifts leave V equal to N xor C
  assert_shift_v_R8: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (flag_we_i && (op == OP_LSL || op == OP_ASR)) |=>
      (ccr_q[FLG_V] == (ccr_q[FLG_N] ^ ccr_q[FLG_C])));

  // R9: multiply carry follows product bit 7
  assert_mul_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (flag_we_i && op == OP_MUL) |=> (ccr_q[FLG_C] == $past(res_o[MSB])));

  // R10: mask ANDs the previous nibble
  assert_mask_and_R10: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (flag_we_i && op == OP_MASK) |=>
      (ccr_q == ($past(ccr_q) & $past(opb_i[FLAG_W-1:0]))));

  // R4: test clears V and C
  assert_test_vc_R4: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (flag_we_i && op == OP_TST) |=> (ccr_q[1:0] == 2'b00));

  // R3: compare never marks a write
  always_comb begin
    if (rst_sn && (op == OP_CMPB || op == OP_CMPW || op == OP_TST || op == OP_BIT))
      assert_no_write_R3: assert (!res_wr_o);
  end
endmodule

// File: tb/nzvc_alu_tb.sv
module nzvc_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 29;

  // {op, opa, opb, res, wr, ccr, pad} as 16 hex digits
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0_007F_0001_0080_1_A_0,  // R1 add signed overflow
    64'h0_00FF_0001_0000_1_5_0,  // R1 add carry, zero
    64'h1_0000_0001_00FF_1_9_0,  // R2 sub borrow
    64'h1_0080_0001_007F_1_2_0,  // R2 sub overflow
    64'h2_0010_0010_0000_0_4_0,  // R3 byte compare equal
    64'h3_1234_8000_9234_0_B_0,  // R3 wide compare
    64'h2_0005_0009_00FC_0_9_0,  // R3 byte compare below
    64'h5_00F0_003C_0030_1_1_0,  // R5 and keeps C
    64'h6_00AA_0055_00FF_1_9_0,  // R5 eor
    64'h7_000F_00F0_0000_0_5_0,  // R5 bit test
    64'h4_0080_0000_0080_0_8_0,  // R4 test negative
    64'h4_0000_0000_0000_0_4_0,  // R4 test zero
    64'h9_005A_0000_00A5_1_9_0,  // R6 complement
    64'h8_0055_0000_0000_1_4_0,  // R6 clear
    64'hA_0001_0000_00FF_1_9_0,  // R7 negate one
    64'hA_0080_0000_0080_1_B_0,  // R7 negate 0x80
    64'hA_0000_0000_0000_1_4_0,  // R7 negate zero
    64'hB_00C1_0000_0082_1_9_0,  // R8 lsl
    64'hB_0040_0000_0080_1_A_0,  // R8 lsl into sign
    64'hC_0081_0000_00C0_1_9_0,  // R8 asr negative
    64'hC_0002_0000_0001_1_0_0,  // R8 asr positive
    64'hC_0001_0000_0000_1_7_0,  // R8 asr to zero
    64'hD_00FF_00FF_FE01_1_6_0,  // R9 mul, C from bit 7 = 0
    64'hD_0010_0008_0080_1_7_0,  // R9 mul, C = 1
    64'hE_0000_000A_0000_0_2_0,  // R10 mask
    64'h0_0080_0080_0000_1_7_0,  // R1 add both negative
    64'hE_0000_00F0_0000_0_0_0,  // R10 mask clears all
    64'h3_ABCD_ABCD_0000_0_4_0,  // R3 wide equal
    64'hF_1111_2222_0000_0_4_0   // R10 nop
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [15:0] opa;
  logic [15:0] opb;
  logic        we;
  logic [15:0] res;
  logic        res_wr;
  logic [3:0]  ccr;

  int checks;
  int errors;

  nzvc_alu u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_i      (op),
    .opa_i     (opa),
    .opb_i     (opb),
    .flag_we_i (we),
    .res_o     (res),
    .res_wr_o  (res_wr),
    .ccr_o     (ccr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4: return "R4";
      4'h5, 4'h6, 4'h7: return "R5";
      4'h8, 4'h9: return "R6";
      4'hA: return "R7";
      4'hB, 4'hC: return "R8";
      4'hD: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [15:0] a, logic [15:0] b, logic w);
    @(negedge clk);
    op = o; opa = a; opb = b; we = w;
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; op = 4'hF; opa = '0; opb = '0; we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R12", {12'h0, ccr}, 16'h0, "flags in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      apply(v[63:60], v[59:44], v[43:28], 1'b1);
      check(tag_of(v[63:60]), {15'h0, res_wr}, {15'h0, v[8]}, "write mark");
      if (v[8]) check(tag_of(v[63:60]), res, v[27:12], "result");
      @(posedge clk); #1;
      check(tag_of(v[63:60]), {12'h0, ccr}, {12'h0, v[7:4]}, "flags");
    end

    // R11: enable low, operation that would change every flag
    apply(4'h0, 16'h007F, 16'h0001, 1'b0);
    check("R1", res, 16'h0080, "result with flags off");
    @(posedge clk); #1;
    check("R11", {12'h0, ccr}, 16'h4, "flags hold with enable low");
    apply(4'h8, 16'h0000, 16'h0000, 1'b0);
    @(posedge clk); #1;
    apply(4'hE, 16'h0000, 16'h0000, 1'b0);
    @(posedge clk); #1;
    check("R11", {12'h0, ccr}, 16'h4, "mask ignored with enable low");

    // R12: flag positions and asynchronous clear
    apply(4'h0, 16'h007F, 16'h0001, 1'b1);
    @(posedge clk); #1;
    check("R12", {12'h0, ccr}, 16'hA, "N at bit 3, V at bit 1");
    @(negedge clk); rst_n = 1'b0; #1;
    check("R12", {12'h0, ccr}, 16'h0, "async clear");
    @(negedge clk); rst_n = 1'b1; we = 1'b0;
    repeat (4) @(posedge clk); #1;
    check("R12", {12'h0, ccr}, 16'h0, "after reset release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule